// File: doc/BRIEF.md
# Triggered Sample Capture Sequencer

This block sits between an A/D sample stream and the packer of one channel's FIFO, and decides which samples the FIFO stores. A 9-bit control word enables the channel, chooses between a single block capture and an open-ended continuous capture, and picks the start condition. The start condition is a rising, falling or either edge on one of two external trigger lines, or a software pulse. The software pulse is a module-wide input, so one pulse starts every channel armed for it in the same cycle.

Once started, the sequencer discards a programmable number of leading samples. It then stores one sample and passes over the next N, where N is the skip count. It raises a sticky completion flag when the programmed number of samples has been stored. In single mode it then stops until re-armed. In continuous mode it keeps storing until the enable bit drops. The external lines are resynchronised before their edges are detected.

Top module: `capture_sequencer`

## Requirements
- R1: While reset is low and on the first cycle after it, `store_stb` and `sample_done` are 0.
- R2: In single mode (control bits [1:0] = 1), exactly `block_len` samples are stored after the trigger, each presented on `store_data` one cycle after its `smp_valid` cycle. Later samples are not stored.
- R3: After a trigger, the first `delay_len` valid samples are discarded. Storing starts with the next one.
- R4: With a skip count N, the first sample after the delay is stored, the following N valid samples are passed over, and the pattern repeats.
- R5: `sample_done` rises in the same cycle as the store strobe of the `block_len`-th stored sample, and not earlier. With `block_len` = 0 it rises one cycle after the trigger and single mode stores nothing.
- R6: In single mode, after completion, neither further samples nor further triggers cause stores until the control word is re-armed: bit 8 goes to 0 and back to 1.
- R7: In continuous mode (control bits [1:0] = 0), storing carries on past `block_len` with the same delay and skip pattern, and `sample_done` is set at `block_len`.
- R8: When control bit 8 is 0, no sample is stored, whatever the mode.
- R9: Control bits [5:4] select the start: 0 a rising edge, 1 a falling edge, 2 either edge of the selected external line, 3 a `sw_trig` pulse. An external edge takes effect three clock edges after it reaches the pin.
- R10: `ext_sel` picks which bit of `ext_trig` is watched, with index 0 being the first line. Edges on the other line do not start a capture.
- R11: `sample_done` stays set while the channel is disabled. It clears on a `fifo_clear` pulse and when bit 8 rises.
- R12: A trigger event that does not match the selected start condition, or that arrives while bit 8 is 0, does not start a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A new converter sample is on `smp_data` |
| smp_data | input | DATA_W | Sample value |
| ext_trig | input | EXT_LINES | Asynchronous external trigger lines |
| ext_sel | input | SEL_W | Index of the watched external line |
| sw_trig | input | 1 | Module-wide software trigger pulse |
| trig_ctrl | input | 9 | Bit 8 enable, [5:4] start condition, [1:0] mode |
| delay_len | input | CNT_W | Samples discarded after the trigger |
| skip_len | input | SKIP_W | Samples passed over between stores |
| block_len | input | CNT_W | Stored samples that complete a capture |
| fifo_clear | input | 1 | Clears the completion flag |
| store_stb | output | 1 | Write one word into the FIFO |
| store_data | output | DATA_W | Word to write |
| sample_done | output | 1 | Sticky completion flag |

## Verification
The hardest case to reach is the moment after a single capture has finished while the channel is still enabled. Only an idle-looking port state tells whether the sequencer has truly stopped or is waiting to re-trigger. The bench completes a capture, then fires a fresh software pulse and feeds more samples. Any store in that window appears in the scoreboard as an unexpected item. The falling-edge and either-edge starts also need the watched line already in its opposite level before the channel is armed, so the bench parks the line in that level, arms, waits through the synchroniser, and only then toggles it.

// File: rtl/cap_pkg.sv
// Package: shared types and control-word decode for the capture sequencer.
// Assumes the 9-bit control word layout: [8] enable, [5:4] start, [1:0] mode.
package cap_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT,
        ST_DELAY,
        ST_RUN,
        ST_FINI
    } cap_state_t;

    localparam int          CTRL_W    = 9;
    localparam int          EN_BIT    = 8;
    localparam logic [1:0]  START_POS = 2'd0;
    localparam logic [1:0]  START_NEG = 2'd1;
    localparam logic [1:0]  START_ANY = 2'd2;
    localparam logic [1:0]  START_SW  = 2'd3;
    localparam logic [1:0]  MODE_ONE  = 2'd1;

    // Returns 1 when the observed events satisfy the chosen start condition.
    function automatic logic start_hit(input logic [1:0] start,
                                       input logic rise,
                                       input logic fall,
                                       input logic sw);
        unique case (start)
            START_POS: return rise;
            START_NEG: return fall;
            START_ANY: return rise | fall;
            default:   return sw;
        endcase
    endfunction

endpackage

// File: rtl/cap_edge_sync.sv
// Module: cap_edge_sync
// Brings each asynchronous trigger line into the clock domain through two
// flops, then flags a rising or falling transition for one cycle.
// Assumes each line holds a level for at least two clock cycles.
module cap_edge_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic meta_q, sync_q, prev_q;

        // Two-stage synchroniser plus one history flop for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= line_in[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        // Edge flags from the synchronised level and its previous value.
        always_comb begin
            rise[g] = sync_q & ~prev_q;
            fall[g] = ~sync_q & prev_q;
        end

        // R9: a detected edge lasts exactly one cycle.
        a_r9_rise_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
        a_r9_fall_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            fall[g] |=> !fall[g]);
    end

endmodule

// File: rtl/cap_trig_decode.sv
// Module: cap_trig_decode
// Selects one external line and reduces its edges and the software pulse to
// a single start event for the chosen start condition. Purely combinational.
// Assumes sel is below LINES.
module cap_trig_decode
    import cap_pkg::*;
#(
    parameter int LINES = 2,
    localparam int SEL_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic [LINES-1:0] rise,
    input  logic [LINES-1:0] fall,
    input  logic [SEL_W-1:0] sel,
    input  logic             sw_pulse,
    input  logic [1:0]       start,
    output logic             fire
);

    // Pick the watched line and apply the start condition.
    always_comb begin
        fire = start_hit(start, rise[sel], fall[sel], sw_pulse);
    end

endmodule

// File: rtl/cap_fsm.sv
// Module: cap_fsm
// Capture state machine: waits for a start event, discards delay samples,
// stores one sample then passes over skip samples, and counts stored samples
// up to the block length. Completion flag is sticky.
// Assumes fire is a one-cycle event and the length inputs are steady while armed.
module cap_fsm
    import cap_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int SKIP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              single,
    input  logic              fire,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [CNT_W-1:0]  delay_len,
    input  logic [SKIP_W-1:0] skip_len,
    input  logic [CNT_W-1:0]  block_len,
    input  logic              fifo_clear,
    output logic              store_stb,
    output logic [DATA_W-1:0] store_data,
    output logic              done
);

    cap_state_t        state, st_n;
    logic              en_q;
    logic              take, fin;
    logic [CNT_W-1:0]  dly_left;
    logic [CNT_W-1:0]  stored;
    logic [SKIP_W-1:0] skip_left;
    logic [CNT_W:0]    stored_nx;

    // Stored count after one more store, one bit wider to avoid wrap.
    always_comb begin
        stored_nx = {1'b0, stored} + {{CNT_W{1'b0}}, 1'b1};
    end

    // Next state, store decision and completion event.
    always_comb begin
        st_n = state;
        take = 1'b0;
        fin  = 1'b0;
        unique case (state)
            ST_OFF: if (en) st_n = ST_WAIT;
            ST_WAIT: begin
                if (!en) st_n = ST_OFF;
                else if (fire) begin
                    fin = (block_len == '0);
                    if (fin && single)         st_n = ST_FINI;
                    else if (delay_len != '0)  st_n = ST_DELAY;
                    else                       st_n = ST_RUN;
                end
            end
            ST_DELAY: begin
                if (!en) st_n = ST_OFF;
                else if (smp_valid && dly_left == {{(CNT_W-1){1'b0}}, 1'b1})
                    st_n = ST_RUN;
            end
            ST_RUN: begin
                if (!en) st_n = ST_OFF;
                else begin
                    take = smp_valid && (skip_left == '0);
                    fin  = take && (stored_nx == {1'b0, block_len});
                    if (fin && single) st_n = ST_FINI;
                end
            end
            ST_FINI: if (!en) st_n = ST_OFF;
            default: st_n = ST_OFF;
        endcase
    end

    // State, counters, store output and sticky completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_OFF;
            en_q       <= 1'b0;
            dly_left   <= '0;
            stored     <= '0;
            skip_left  <= '0;
            store_stb  <= 1'b0;
            store_data <= '0;
            done       <= 1'b0;
        end else begin
            state     <= st_n;
            en_q      <= en;
            store_stb <= take;
            if (take) store_data <= smp_data;

            if (state == ST_WAIT && en && fire) begin
                dly_left  <= delay_len;
                stored    <= '0;
                skip_left <= '0;
            end else if (state == ST_DELAY && en && smp_valid) begin
                dly_left <= dly_left - 1'b1;
            end else if (take) begin
                skip_left <= skip_len;
                if (stored != '1) stored <= stored + 1'b1;
            end else if (state == ST_RUN && en && smp_valid) begin
                skip_left <= skip_left - 1'b1;
            end

            if (fifo_clear || (en && !en_q)) done <= 1'b0;
            else if (fin)                    done <= 1'b1;
        end
    end

    // R8: a disabled channel never produces a store on the next cycle.
    a_r8_disabled_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !store_stb);
    // R3: no store follows a cycle spent discarding.
    a_r3_delay_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY) |=> !store_stb);
    // R6: a finished single capture stays silent.
    a_r6_fini_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINI) |=> !store_stb);
    // R2: every store is caused by a valid sample one cycle earlier.
    a_r2_store_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
        store_stb |-> $past(smp_valid));
    // R11: a clear request always leaves the flag low.
    a_r11_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clear |=> !done);
    // R5: the flag only rises alongside a store or right after a start.
    a_r5_done_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (store_stb || $past(state == ST_WAIT)));

endmodule

// File: rtl/capture_sequencer.sv
// Module: capture_sequencer (top)
// Decides which A/D samples enter one channel FIFO: synchronises the external
// trigger lines, decodes the control word, and runs the capture state machine.
// Assumes sw_trig is a one-cycle pulse shared by every channel of the module.
module capture_sequencer
    import cap_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 16,
    parameter int SKIP_W    = 16,
    parameter int EXT_LINES = 2,
    localparam int SEL_W    = (EXT_LINES > 1) ? $clog2(EXT_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic [DATA_W-1:0]    smp_data,
    input  logic [EXT_LINES-1:0] ext_trig,
    input  logic [SEL_W-1:0]     ext_sel,
    input  logic                 sw_trig,
    input  logic [8:0]           trig_ctrl,
    input  logic [CNT_W-1:0]     delay_len,
    input  logic [SKIP_W-1:0]    skip_len,
    input  logic [CNT_W-1:0]     block_len,
    input  logic                 fifo_clear,
    output logic                 store_stb,
    output logic [DATA_W-1:0]    store_data,
    output logic                 sample_done
);

    logic [EXT_LINES-1:0] ext_rise, ext_fall;
    logic                 start_fire;
    logic                 ch_en, one_shot;
    logic                 ctrl_unused;

    // Control word fields; bits 7:6 and 3:2 carry no meaning.
    always_comb begin
        ch_en       = trig_ctrl[EN_BIT];
        one_shot    = (trig_ctrl[1:0] == MODE_ONE);
        ctrl_unused = ^{trig_ctrl[7:6], trig_ctrl[3:2]};
    end

    cap_edge_sync #(.LINES(EXT_LINES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (ext_trig),
        .rise    (ext_rise),
        .fall    (ext_fall)
    );

    cap_trig_decode #(.LINES(EXT_LINES)) i_decode (
        .rise     (ext_rise),
        .fall     (ext_fall),
        .sel      (ext_sel),
        .sw_pulse (sw_trig),
        .start    (trig_ctrl[5:4]),
        .fire     (start_fire)
    );

    cap_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SKIP_W(SKIP_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ch_en),
        .single     (one_shot),
        .fire       (start_fire),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .delay_len  (delay_len),
        .skip_len   (skip_len),
        .block_len  (block_len),
        .fifo_clear (fifo_clear),
        .store_stb  (store_stb),
        .store_data (store_data),
        .done       (sample_done)
    );

endmodule

// File: tb/test_capture_sequencer.sv
// Scoreboard bench: tasks push the stores the requirements predict, a monitor
// pops and compares each store the design makes.
module test_capture_sequencer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [15:0] smp_data;
    logic [1:0]  ext_trig;
    logic [0:0]  ext_sel;
    logic        sw_trig;
    logic [8:0]  trig_ctrl;
    logic [15:0] delay_len, skip_len, block_len;
    logic        fifo_clear;
    logic        store_stb;
    logic [15:0] store_data;
    logic        sample_done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    capture_sequencer i_capture_sequencer (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .ext_trig(ext_trig), .ext_sel(ext_sel), .sw_trig(sw_trig),
        .trig_ctrl(trig_ctrl), .delay_len(delay_len), .skip_len(skip_len),
        .block_len(block_len), .fifo_clear(fifo_clear), .store_stb(store_stb),
        .store_data(store_data), .sample_done(sample_done)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: every store must match the head of the expected queue (R2).
    always @(negedge clk) begin
        if (rst_n && store_stb) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected store actual=%h expected=none", store_data);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (store_data !== e) begin
                    errors++;
                    $display("FAIL R2 store data actual=%h expected=%h", store_data, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Arm with a disable cycle first, so bit 8 rises.
    task automatic arm(input logic [8:0] c, input int d, input int s, input int n);
        trig_ctrl = 9'h000;
        tick(1);
        delay_len = 16'(d); skip_len = 16'(s); block_len = 16'(n);
        trig_ctrl = c;
        tick(1);
    endtask

    task automatic pulse_sw();
        sw_trig = 1'b1;
        tick(1);
        sw_trig = 1'b0;
    endtask

    // Predict stores for cnt samples after a start: delay, skip, block length.
    task automatic expect_cap(input int d, input int s, input int n, input bit one,
                              input int cnt, input int base);
        int taken = 0;
        for (int i = 0; i < cnt; i++) begin
            if (i >= d && ((i - d) % (s + 1)) == 0 && (!one || taken < n)) begin
                exp_q.push_back(16'(base + i));
                taken++;
            end
        end
    endtask

    // Driver: one valid sample every other cycle.
    task automatic feed(input int cnt, input int base);
        for (int i = 0; i < cnt; i++) begin
            smp_valid = 1'b1;
            smp_data  = 16'(base + i);
            tick(1);
            smp_valid = 1'b0;
            tick(1);
        end
    endtask

    task automatic settle_empty(input string tag);
        tick(2);
        check_eq(tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; ext_trig = '0; ext_sel = '0;
        sw_trig = 1'b0; trig_ctrl = '0; delay_len = '0; skip_len = '0;
        block_len = '0; fifo_clear = 1'b0;
        tick(3);
        check_eq("R1 store_stb in reset", store_stb, 0);
        check_eq("R1 done in reset", sample_done, 0);
        rst_n = 1'b1;
        tick(1);
        check_eq("R1 done after reset", sample_done, 0);

        // R2 / R5: single block of 4, software start.
        arm(9'h131, 0, 0, 4);
        pulse_sw();
        expect_cap(0, 0, 4, 1, 6, 16'h100);
        feed(6, 16'h100);
        settle_empty("R2 single block");
        check_eq("R5 done after block", sample_done, 1);

        // R6: retrigger after completion is ignored.
        pulse_sw();
        feed(3, 16'h180);
        settle_empty("R6 no store after finish");

        // R3: delay discards samples; R11 re-arm clears flag.
        arm(9'h131, 3, 0, 2);
        check_eq("R11 rearm clears done", sample_done, 0);
        pulse_sw();
        expect_cap(3, 0, 2, 1, 7, 16'h200);
        feed(7, 16'h200);
        settle_empty("R3 delay discard");

        // R4: skip pattern.
        arm(9'h131, 1, 2, 3);
        pulse_sw();
        expect_cap(1, 2, 3, 1, 12, 16'h300);
        feed(12, 16'h300);
        settle_empty("R4 skip pattern");

        // R5: flag not early, then set on last store.
        arm(9'h131, 0, 0, 3);
        pulse_sw();
        expect_cap(0, 0, 3, 1, 2, 16'h400);
        feed(2, 16'h400);
        settle_empty("R5 partial block");
        check_eq("R5 done not early", sample_done, 0);
        exp_q.push_back(16'h402);
        feed(1, 16'h402);
        settle_empty("R5 last store");
        check_eq("R5 done on last", sample_done, 1);

        // R5: zero length completes at start, stores nothing.
        arm(9'h131, 0, 0, 0);
        pulse_sw();
        tick(1);
        check_eq("R5 zero length done", sample_done, 1);
        feed(2, 16'h480);
        settle_empty("R5 zero length no store");

        // R7: continuous keeps storing past the block length.
        arm(9'h130, 1, 0, 2);
        pulse_sw();
        expect_cap(1, 0, 2, 0, 6, 16'h500);
        feed(6, 16'h500);
        settle_empty("R7 continuous");
        check_eq("R7 done in continuous", sample_done, 1);

        // R8: disable stops storing; R11 flag sticky, then cleared.
        trig_ctrl = 9'h030;
        tick(1);
        feed(3, 16'h580);
        settle_empty("R8 disabled no store");
        check_eq("R11 done sticky while off", sample_done, 1);
        fifo_clear = 1'b1; tick(1); fifo_clear = 1'b0; tick(1);
        check_eq("R11 clear drops done", sample_done, 0);

        // R9: rising edge on line 0.
        ext_sel = 1'b0;
        arm(9'h101, 0, 0, 2);
        ext_trig[0] = 1'b1;
        tick(4);
        expect_cap(0, 0, 2, 1, 3, 16'h600);
        feed(3, 16'h600);
        settle_empty("R9 rising edge");

        // R9: falling edge; the line already sits high.
        arm(9'h111, 0, 0, 2);
        tick(4);
        ext_trig[0] = 1'b0;
        tick(4);
        expect_cap(0, 0, 2, 1, 3, 16'h700);
        feed(3, 16'h700);
        settle_empty("R9 falling edge");

        // R9: either edge, rising then falling.
        arm(9'h121, 0, 0, 1);
        ext_trig[0] = 1'b1;
        tick(4);
        expect_cap(0, 0, 1, 1, 2, 16'h800);
        feed(2, 16'h800);
        settle_empty("R9 any edge rise");
        arm(9'h121, 0, 0, 1);
        tick(4);
        ext_trig[0] = 1'b0;
        tick(4);
        expect_cap(0, 0, 1, 1, 2, 16'h880);
        feed(2, 16'h880);
        settle_empty("R9 any edge fall");

        // R10: edge on the other line is ignored, then selecting it works.
        arm(9'h101, 0, 0, 2);
        ext_trig[1] = 1'b1;
        tick(4);
        feed(3, 16'h900);
        settle_empty("R10 unselected line");
        check_eq("R10 done stays low", sample_done, 0);
        ext_sel = 1'b1;
        ext_trig[1] = 1'b0;
        tick(4);
        ext_trig[1] = 1'b1;
        tick(4);
        expect_cap(0, 0, 2, 1, 3, 16'h980);
        feed(3, 16'h980);
        settle_empty("R10 selected line");

        // R12: software pulse in edge mode, and pulse while disabled.
        arm(9'h101, 0, 0, 2);
        pulse_sw();
        feed(3, 16'hA00);
        settle_empty("R12 sw in edge mode");
        trig_ctrl = 9'h031;
        tick(1);
        pulse_sw();
        trig_ctrl = 9'h131;
        tick(2);
        feed(3, 16'hA80);
        settle_empty("R12 sw while disabled");

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule